// File: doc/BRIEF.md
# Hard-Decision Bit-Flipping Decoder for Quasi-Cyclic Parity-Check Codes

This block corrects a hard-decision received word of `N = M*L` bits against a fixed sparse parity-check matrix. The matrix is built from `L` square circulant blocks of size `M`, and each block is given only by its first row. Each decoding pass first forms every syndrome bit. It then counts, for every bit position, how many failing checks that bit takes part in. Finally it inverts every bit whose count equals the largest count in that pass.

A host writes the received word while the decoder is idle and then pulses `start`. The decoder repeats its three-phase pass until the syndrome is all zero or a preset pass limit is reached. It then raises `done` for one cycle and presents the resulting word, a success or failure flag, and the number of passes it used. These outputs stay valid until the next start.

Top module: `bf_ldpc_decoder`

## Requirements
- R1: The check matrix has M rows and N columns. Entry (row j, column b) equals bit ((b mod M) - j) mod M of the first row of circulant b/M, where that first row occupies bits [i*M +: M] of `FIRST_ROWS` and bit k is the coefficient of x^k. Syndrome bit j is the XOR of the word bits in the columns where row j holds a 1.
- R2: A word whose syndrome is zero at start finishes with `dec_ok`=1, `dec_fail`=0, `iters`=0 and `word_out` equal to the loaded word.
- R3: In every pass with a nonzero syndrome, each bit is given the number of failing checks it belongs to. Every bit whose count equals the maximum over all bits is inverted in the same pass, and no other bit changes.
- R4: With k passes performed, `done` is high right after the (1+3k)-th rising edge that follows the edge sampling `start`, and `iters` equals k.
- R5: If the syndrome is still nonzero after MAX_ITER passes (default 10), decoding ends with `dec_fail`=1, `dec_ok`=0, `iters`=MAX_ITER, and `word_out` equal to the word after the last pass.
- R6: `busy` is high from the edge after `start` is taken until the edge that raises `done`, and it is low while `done` is high. `done` is high for exactly one cycle.
- R7: `load_en` is obeyed only while idle. A load during decoding does not change that run's result.
- R8: `start` while busy is ignored. It neither restarts the run nor changes its latency.
- R9: After reset, all outputs are zero. `dec_ok` and `dec_fail` are never both high. Both clear on an accepted start, and both hold their values from `done` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_word` into the working word (idle only) |
| load_word | input | N | Received hard-decision word |
| start | input | 1 | Begin decoding the working word |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle end-of-decode pulse |
| dec_ok | output | 1 | Last run reached a zero syndrome |
| dec_fail | output | 1 | Last run hit the pass limit |
| iters | output | IW | Passes used by the last run |
| word_out | output | N | Word at the end of the last run |

## Verification
All results are due at a fixed edge. A clean word finishes one edge after the start edge, and each pass adds three edges (syndrome, count, flip), so a run of k passes completes 1+3k edges after start. The bench counts rising edges from the start edge and samples 1 ns after each edge. At the edge where `done` first appears, it compares the latency to 1+3k, using the k from its own reference model. It also checks `busy` at every sampled edge before `done`, and verifies that `busy` is low at `done`.

// File: rtl/bf_ldpc_pkg.sv
package bf_ldpc_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SYN  = 2'd1,
    S_CNT  = 2'd2,
    S_FLIP = 2'd3
  } bf_state_e;

  // Index into the concatenated first-row vector for entry (row, col).
  function automatic int rot_index(input int m, input int row, input int col);
    int blk;
    int c;
    blk = col / m;
    c   = col % m;
    return blk * m + ((c - row + m) % m);
  endfunction

endpackage

// File: rtl/bf_syndrome.sv
module bf_syndrome #(
  parameter int M = 15,
  parameter int L = 2,
  parameter logic [M*L-1:0] FIRST_ROWS = '0,
  localparam int N = M * L
) (
  input  logic [N-1:0] word,
  output logic [M-1:0] syn
);
  import bf_ldpc_pkg::*;

  always_comb begin
    for (int j = 0; j < M; j++) begin
      logic acc;
      acc = 1'b0;
      for (int b = 0; b < N; b++) begin
        if (FIRST_ROWS[rot_index(M, j, b)]) acc = acc ^ word[b];
      end
      syn[j] = acc;
    end
  end
endmodule

// File: rtl/bf_fail_count.sv
module bf_fail_count #(
  parameter int M = 15,
  parameter int L = 2,
  parameter logic [M*L-1:0] FIRST_ROWS = '0,
  localparam int N = M * L,
  localparam int CW = $clog2(M + 1)
) (
  input  logic [M-1:0]         syn,
  output logic [N-1:0][CW-1:0] cnt
);
  import bf_ldpc_pkg::*;

  for (genvar b = 0; b < N; b++) begin : g_col
    always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int j = 0; j < M; j++) begin
        if (FIRST_ROWS[rot_index(M, j, b)]) acc = acc + {{(CW-1){1'b0}}, syn[j]};
      end
      cnt[b] = acc;
    end
  end
endmodule

// File: rtl/bf_flip_select.sv
module bf_flip_select #(
  parameter int N = 30,
  parameter int CW = 4
) (
  input  logic [N-1:0][CW-1:0] cnt,
  output logic [N-1:0]         mask
);
  logic [CW-1:0] top;

  always_comb begin
    top = '0;
    for (int b = 0; b < N; b++) begin
      if (cnt[b] > top) top = cnt[b];
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_sel
    assign mask[b] = (top != '0) && (cnt[b] == top);
  end
endmodule

// File: rtl/bf_ldpc_decoder.sv
module bf_ldpc_decoder #(
  parameter int M = 15,
  parameter int L = 2,
  parameter int MAX_ITER = 10,
  parameter logic [M*L-1:0] FIRST_ROWS = {15'h000B, 15'h0221},
  localparam int N = M * L,
  localparam int CW = $clog2(M + 1),
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [N-1:0]  load_word,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          dec_ok,
  output logic          dec_fail,
  output logic [IW-1:0] iters,
  output logic [N-1:0]  word_out
);
  import bf_ldpc_pkg::*;

  bf_state_e           state;
  logic [N-1:0]        word_q;
  logic [M-1:0]        syn_c, syn_q;
  logic [N-1:0][CW-1:0] cnt_c, cnt_q;
  logic [N-1:0]        flip_mask;
  logic [IW-1:0]       iter_q;

  bf_syndrome #(.M(M), .L(L), .FIRST_ROWS(FIRST_ROWS)) u_syn (
    .word(word_q), .syn(syn_c)
  );

  bf_fail_count #(.M(M), .L(L), .FIRST_ROWS(FIRST_ROWS)) u_cnt (
    .syn(syn_q), .cnt(cnt_c)
  );

  bf_flip_select #(.N(N), .CW(CW)) u_sel (
    .cnt(cnt_q), .mask(flip_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      word_q   <= '0;
      syn_q    <= '0;
      cnt_q    <= '0;
      iter_q   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      dec_ok   <= 1'b0;
      dec_fail <= 1'b0;
      iters    <= '0;
      word_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (load_en) word_q <= load_word;
          if (start) begin
            state    <= S_SYN;
            busy     <= 1'b1;
            iter_q   <= '0;
            dec_ok   <= 1'b0;
            dec_fail <= 1'b0;
          end
        end
        S_SYN: begin
          if (syn_c == '0 || iter_q == IW'(MAX_ITER)) begin
            state    <= S_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            dec_ok   <= (syn_c == '0);
            dec_fail <= (syn_c != '0);
            iters    <= iter_q;
            word_out <= word_q;
          end else begin
            syn_q <= syn_c;
            state <= S_CNT;
          end
        end
        S_CNT: begin
          cnt_q <= cnt_c;
          state <= S_FLIP;
        end
        S_FLIP: begin
          word_q <= word_q ^ flip_mask;
          iter_q <= iter_q + 1'b1;
          state  <= S_SYN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: a pass entered with failing checks always changes the word
  a_r3_pass_flips: assert property (@(posedge clk) disable iff (rst)
    (state == S_FLIP) |=> (word_q != $past(word_q)));

  // R4: the three phases follow each other without stalls
  a_r4_cnt_to_flip: assert property (@(posedge clk) disable iff (rst)
    (state == S_CNT) |=> (state == S_FLIP));
  a_r4_flip_to_syn: assert property (@(posedge clk) disable iff (rst)
    (state == S_FLIP) |=> (state == S_SYN));

  // R5: failure is only reported at the pass limit
  a_r5_fail_at_cap: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_fail) |-> (iters == IW'(MAX_ITER)));

  // R6: done is a single pulse and never overlaps busy
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: outcome flags are exclusive
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(dec_ok && dec_fail));

  // R7: the working word only changes in a flip phase or an idle load
  a_r7_word_guard: assert property (@(posedge clk) disable iff (rst)
    (busy && state != S_FLIP) |=> $stable(word_q));

endmodule

// File: tb/sim_bf_ldpc_decoder.sv
module sim_bf_ldpc_decoder;
  localparam int M = 15;
  localparam int L = 2;
  localparam int N = M * L;
  localparam int MAXI = 10;
  localparam int IW = $clog2(MAXI + 1);
  localparam logic [N-1:0] ROWS = {15'h000B, 15'h0221};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [N-1:0] load_word = '0;
  logic start = 1'b0;
  logic busy, done, dec_ok, dec_fail;
  logic [IW-1:0] iters;
  logic [N-1:0] word_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  bf_ldpc_decoder #(.M(M), .L(L), .MAX_ITER(MAXI), .FIRST_ROWS(ROWS)) u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
    .start(start), .busy(busy), .done(done), .dec_ok(dec_ok),
    .dec_fail(dec_fail), .iters(iters), .word_out(word_out)
  );

  task automatic check(input bit cond, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: matrix entry as defined in R1
  function automatic bit hb(input int j, input int b);
    int i;
    int c;
    i = b / M;
    c = b % M;
    return ROWS[i * M + ((c - j + M) % M)];
  endfunction

  task automatic model(input logic [N-1:0] w0, output logic [N-1:0] w,
                       output bit ok, output int it);
    logic [M-1:0] s;
    int cnt [N];
    int mx;
    w = w0;
    it = 0;
    ok = 0;
    while (1) begin
      for (int j = 0; j < M; j++) begin
        s[j] = 0;
        for (int b = 0; b < N; b++) if (hb(j, b)) s[j] ^= w[b];
      end
      if (s == '0) begin ok = 1; return; end
      if (it == MAXI) begin ok = 0; return; end
      mx = 0;
      for (int b = 0; b < N; b++) begin
        cnt[b] = 0;
        for (int j = 0; j < M; j++) if (hb(j, b) && s[j]) cnt[b]++;
        if (cnt[b] > mx) mx = cnt[b];
      end
      for (int b = 0; b < N; b++) if (mx != 0 && cnt[b] == mx) w[b] = ~w[b];
      it++;
    end
  endtask

  // Load, start and wait; optional disturbance at the first busy edge.
  task automatic run_dec(input logic [N-1:0] w, input bit disturb,
                         output int lat, output bit busy_ok);
    @(negedge clk);
    load_en = 1'b1; load_word = w;
    @(negedge clk);
    load_en = 1'b0; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    busy_ok = 1;
    while (1) begin
      @(posedge clk);
      lat++;
      #1;
      if (disturb && lat == 1) begin
        load_en = 1'b1; load_word = ~w; start = 1'b1;
      end else begin
        load_en = 1'b0; start = 1'b0;
      end
      if (done) begin
        if (busy) busy_ok = 0;
        break;
      end
      if (!busy) busy_ok = 0;
      if (lat > 300) break;
    end
  endtask

  task automatic full_check(input logic [N-1:0] w, input string tag);
    logic [N-1:0] ew;
    bit eok;
    int eit;
    int lat;
    bit bo;
    model(w, ew, eok, eit);
    run_dec(w, 0, lat, bo);
    check(word_out == ew, {tag, " R3 word"}, 64'(word_out), 64'(ew));
    check(dec_ok == eok && dec_fail == !eok, {tag, " R5 flags"},
          64'({dec_ok, dec_fail}), 64'({eok, !eok}));
    check(int'(iters) == eit, {tag, " R4 iters"}, 64'(iters), 64'(eit));
    check(lat == 1 + 3 * eit, {tag, " R4 latency"}, 64'(lat), 64'(1 + 3 * eit));
    check(bo, {tag, " R6 busy"}, 64'(bo), 64'd1);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R9 reset busy/done", 64'({busy, done}), 64'd0);
    check(!dec_ok && !dec_fail, "R9 reset flags", 64'({dec_ok, dec_fail}), 64'd0);
    check(iters == '0 && word_out == '0, "R9 reset outputs", 64'(word_out), 64'd0);
  endtask

  task automatic t_codewords();
    int lat;
    bit bo;
    run_dec('0, 0, lat, bo);
    check(dec_ok && iters == '0 && word_out == '0, "R2 zero word",
          64'({dec_ok, iters}), 64'({1'b1, 4'd0}));
    check(lat == 1, "R4 clean latency", 64'(lat), 64'd1);
    run_dec({N{1'b1}}, 0, lat, bo);
    check(dec_ok && iters == '0 && word_out == {N{1'b1}}, "R1 R2 all-ones codeword",
          64'(word_out), 64'({N{1'b1}}));
  endtask

  task automatic t_single();
    int pos [5] = '{0, 7, 14, 15, 29};
    int lat;
    bit bo;
    foreach (pos[k]) begin
      logic [N-1:0] w;
      w = '0;
      w[pos[k]] = 1'b1;
      run_dec(w, 0, lat, bo);
      check(word_out == '0 && dec_ok, "R3 single error fixed", 64'(word_out), 64'd0);
      check(iters == IW'(1) && lat == 4, "R4 single error one pass",
            64'({iters, 8'(lat)}), 64'({4'd1, 8'd4}));
    end
    begin
      logic [N-1:0] w;
      w = {N{1'b1}};
      w[22] = 1'b0;
      run_dec(w, 0, lat, bo);
      check(word_out == {N{1'b1}}, "R1 R3 error on ones codeword", 64'(word_out),
            64'({N{1'b1}}));
    end
  endtask

  task automatic t_multi();
    full_check(30'h0000_0009, "two errors a");
    full_check(30'h0010_0400, "two errors b");
    full_check(30'h2000_8004, "three errors");
    full_check(30'h0F0F_0F0F, "dense pattern");
  endtask

  task automatic t_cap();
    int lat;
    bit bo;
    // Every row sees three ones from block 0: all checks fail, all counts tie,
    // the whole word inverts each pass and oscillates between the two blocks.
    run_dec(30'h0000_7FFF, 0, lat, bo);
    check(dec_fail && !dec_ok, "R5 fail flag", 64'({dec_ok, dec_fail}), 64'd1);
    check(iters == IW'(MAXI), "R5 iters at cap", 64'(iters), 64'(MAXI));
    check(word_out == 30'h0000_7FFF, "R5 R3 word after even passes", 64'(word_out),
          64'h7FFF);
    check(lat == 1 + 3 * MAXI, "R4 R5 latency at cap", 64'(lat), 64'(1 + 3 * MAXI));
    check(bo, "R6 busy during long run", 64'(bo), 64'd1);
    repeat (3) @(posedge clk);
    #1;
    check(dec_fail && !dec_ok && iters == IW'(MAXI), "R9 flags held", 64'(dec_fail), 64'd1);
    @(negedge clk);
    load_en = 1'b1; load_word = '0;
    @(negedge clk);
    load_en = 1'b0; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    check(!dec_fail && !dec_ok && busy, "R9 flags clear on start",
          64'({dec_ok, dec_fail}), 64'd0);
    @(posedge clk);
    #1;
    check(done && dec_ok, "R2 clean after fail", 64'(dec_ok), 64'd1);
  endtask

  task automatic t_disturb();
    int lat;
    bit bo;
    logic [N-1:0] w;
    w = '0;
    w[11] = 1'b1;
    run_dec(w, 1, lat, bo);
    check(word_out == '0 && dec_ok, "R7 load while busy ignored", 64'(word_out), 64'd0);
    check(lat == 4 && iters == IW'(1), "R8 start while busy ignored", 64'(lat), 64'd4);
    check(bo, "R6 busy with disturbance", 64'(bo), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_codewords();
    t_single();
    t_multi();
    t_cap();
    t_disturb();
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule